// File: doc/BRIEF.md
# EEPROM Page Write Buffer

This block gathers the data bytes of one page write for a serial EEPROM and hands them to the memory array once the write is confirmed. A write session opens with a start address. The upper address bits name the page and stay fixed for the whole session. The low bits give the first in-page offset. Each data byte that arrives afterwards goes into a page-sized buffer at the current offset. The offset then steps up, and after the last byte of the page it returns to the first byte of the same page. A byte that lands on a position already loaded in this session replaces the earlier value. A per-position mask records which positions hold new data.

The write is confirmed by the chip-select rise event. This event must come with the byte-aligned flag set and after at least one data byte. If both hold, the block goes busy and drains the loaded positions to the array write port in ascending offset order. Positions that were never loaded are left alone. After the last array write it waits a fixed settle time, then pulses the write-enable clear output and drops busy. A chip-select rise that breaks either condition discards the session, and nothing is written.

Data moves over two valid/ready links. The byte input transfers when `in_valid` and `in_ready` are both high. `in_ready` is low for as long as `busy` is high, and high at every other time. The array port raises `arr_valid` with an address and data. It holds all three unchanged until `arr_ready` is seen high, and the transfer takes place on that clock edge.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy`, `arr_valid` and `wel_clr` are low and `in_ready` is high.
- R2: While the block is not busy, `start_valid` opens a session. The page is taken from `start_addr[15:4]` and the first offset from `start_addr[3:0]`. Each accepted byte is written to the array at address {page, offset}, and the offset then steps up by one.
- R3: An offset that steps past 15 becomes 0 within the same page. The page bits of every array address in a session equal the page bits of its start address.
- R4: When a later byte of the session lands on a position that is already loaded, only the later value is written to the array.
- R5: A `cs_rise` during a session commits the session when `byte_aligned` is 1 and at least one byte has been loaded. `busy` is high from the next cycle.
- R6: A `cs_rise` during a session discards the session when `byte_aligned` is 0 or no byte has been loaded. In that case no array write happens, `busy` stays low and `wel_clr` stays low.
- R7: A commit writes each loaded position exactly once, in ascending offset order. It writes no position that was not loaded.
- R8: While `arr_valid` is high and `arr_ready` is low, `arr_valid`, `arr_addr` and `arr_data` stay unchanged into the next cycle.
- R9: `busy` stays high until `SETTLE_CYC` cycles after the last array transfer. While `busy` is high, `in_ready` is low and `start_valid` and `cs_rise` have no effect.
- R10: `wel_clr` is high for exactly one cycle per commit. That cycle is the last one in which `busy` is high, and `arr_valid` is low in it.
- R11: A byte that is accepted while no session is open is dropped and never reaches the array.
- R12: A byte accepted in the same cycle as a committing `cs_rise` belongs to the session and is written to the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Opens a write session at `start_addr` |
| start_addr | input | 16 | First byte address of the session |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Data byte can be taken (low while busy) |
| in_data | input | 8 | Data byte |
| byte_aligned | input | 1 | The bit count stands on a byte boundary |
| cs_rise | input | 1 | Chip-select rise event, one cycle |
| arr_valid | output | 1 | Array write request |
| arr_ready | input | 1 | The array takes the request |
| arr_addr | output | 16 | Array write address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Write cycle in progress |
| wel_clr | output | 1 | One-cycle pulse that clears the write-enable latch |

## Verification
Two events can fall in the same clock edge. The last data byte can be accepted in the very cycle that the chip-select rise is judged, so the commit decision must count a byte that is not yet in the mask. The bench sometimes puts the final byte's `in_valid` and `cs_rise` in the same cycle, for sessions with one byte and with many. It expects that byte in the array output, and it expects a commit even when that byte is the only one. A second overlap is the final array transfer against the start of the settle count. This is judged by requiring `wel_clr` exactly `SETTLE_CYC` cycles after the last transfer, under random back-pressure on `arr_ready`.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_DRAIN   = 2'd2,
    ST_SETTLE  = 2'd3
  } pwb_state_e;
endpackage

// File: rtl/pwb_low_pick.sv
// Finds the lowest set bit of a vector.
module pwb_low_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pwb_page_store.sv
// Page-sized byte store with a per-position loaded mask.
module pwb_page_store #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  parameter int OFF_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load_en,
  input  logic [OFF_W-1:0]  load_off,
  input  logic [DATA_W-1:0] load_data,
  input  logic              drop_en,
  input  logic [OFF_W-1:0]  drop_off,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [PAGE_BYTES-1:0] mask,
  output logic [DATA_W-1:0] rd_data
);
  logic [PAGE_BYTES-1:0][DATA_W-1:0] bytes_flat;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic              hit_load;
    logic              hit_drop;
    logic              v_q;
    logic [DATA_W-1:0] d_q;

    assign hit_load = load_en && (load_off == OFF_W'(g));
    assign hit_drop = drop_en && (drop_off == OFF_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        if (clear)         v_q <= 1'b0;
        else if (hit_load) v_q <= 1'b1;
        else if (hit_drop) v_q <= 1'b0;
        if (hit_load && !clear) d_q <= load_data;
      end
    end

    assign mask[g]       = v_q;
    assign bytes_flat[g] = d_q;
  end

  assign rd_data = bytes_flat[rd_off];
endmodule

// File: rtl/pwb_ctrl.sv
// Session, commit and write-cycle sequencing.
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 4,
  parameter int SETTLE_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_valid,
  input  logic [ADDR_W-1:0]       start_addr,
  input  logic                    in_valid,
  input  logic                    cs_rise,
  input  logic                    byte_aligned,
  input  logic                    any_loaded,
  input  logic                    last_fire,
  output logic                    busy,
  output logic                    in_ready,
  output logic                    load_en,
  output logic [OFF_W-1:0]        load_off,
  output logic                    clear,
  output logic                    draining,
  output logic [ADDR_W-OFF_W-1:0] page_base,
  output logic                    wel_clr
);
  localparam int BASE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [OFF_W-1:0] OFF_ONE  = OFF_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SETTLE_CYC - 1);

  pwb_state_e       state_q, state_d;
  logic [OFF_W-1:0] ptr_q;
  logic [BASE_W-1:0] base_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_take;
  logic             commit_ok;

  assign busy       = (state_q == ST_DRAIN) || (state_q == ST_SETTLE);
  assign in_ready   = !busy;
  assign draining   = (state_q == ST_DRAIN);
  assign start_take = start_valid && !busy;
  assign load_en    = (state_q == ST_COLLECT) && in_valid && !start_valid;
  assign load_off   = ptr_q;
  assign page_base  = base_q;
  assign commit_ok  = byte_aligned && (any_loaded || load_en);
  assign wel_clr    = (state_q == ST_SETTLE) && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    clear   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_take) begin
          state_d = ST_COLLECT;
          clear   = 1'b1;
        end
      end
      ST_COLLECT: begin
        if (start_take) begin
          clear = 1'b1;
        end else if (cs_rise) begin
          if (commit_ok) begin
            state_d = ST_DRAIN;
          end else begin
            state_d = ST_IDLE;
            clear   = 1'b1;
          end
        end
      end
      ST_DRAIN:  if (last_fire) state_d = ST_SETTLE;
      ST_SETTLE: if (cnt_q == '0) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_take) begin
        ptr_q  <= start_addr[OFF_W-1:0];
        base_q <= start_addr[ADDR_W-1:OFF_W];
      end else if (load_en) begin
        ptr_q <= ptr_q + OFF_ONE;
      end
      if (state_q == ST_DRAIN && last_fire) cnt_q <= CNT_INIT;
      else if (state_q == ST_SETTLE && cnt_q != '0) cnt_q <= cnt_q - CNT_ONE;
    end
  end
endmodule

// File: rtl/page_write_buffer.sv
// Top: page-write byte collector with commit on aligned chip-select rise.
module page_write_buffer #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              byte_aligned,
  input  logic              cs_rise,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy,
  output logic              wel_clr
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFF_W;
  localparam logic [PAGE_BYTES-1:0] MASK_ONE = PAGE_BYTES'(1);

  logic                  load_en;
  logic [OFF_W-1:0]      load_off;
  logic                  clear;
  logic                  draining;
  logic [BASE_W-1:0]     page_base;
  logic [PAGE_BYTES-1:0] mask;
  logic                  any_loaded;
  logic [OFF_W-1:0]      pick;
  logic                  arr_fire;
  logic                  last_fire;

  assign arr_valid = draining && any_loaded;
  assign arr_fire  = arr_valid && arr_ready;
  assign last_fire = arr_fire && ((mask & (mask - MASK_ONE)) == '0);
  assign arr_addr  = {page_base, pick};

  pwb_ctrl #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_addr  (start_addr),
    .in_valid    (in_valid),
    .cs_rise     (cs_rise),
    .byte_aligned(byte_aligned),
    .any_loaded  (any_loaded),
    .last_fire   (last_fire),
    .busy        (busy),
    .in_ready    (in_ready),
    .load_en     (load_en),
    .load_off    (load_off),
    .clear       (clear),
    .draining    (draining),
    .page_base   (page_base),
    .wel_clr     (wel_clr)
  );

  pwb_page_store #(
    .PAGE_BYTES(PAGE_BYTES),
    .DATA_W    (DATA_W),
    .OFF_W     (OFF_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .load_en  (load_en),
    .load_off (load_off),
    .load_data(in_data),
    .drop_en  (arr_fire),
    .drop_off (pick),
    .rd_off   (pick),
    .mask     (mask),
    .rd_data  (arr_data)
  );

  pwb_low_pick #(
    .N    (PAGE_BYTES),
    .IDX_W(OFF_W)
  ) u_pick (
    .vec(mask),
    .any(any_loaded),
    .idx(pick)
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic              busy,
  input logic              arr_valid,
  input logic              arr_ready,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [DATA_W-1:0] arr_data,
  input logic              wel_clr
);
  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && !arr_ready |=> arr_valid && $stable(arr_addr) && $stable(arr_data));

  a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && $past(arr_valid) |-> arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W]));

  a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && $past(arr_valid && arr_ready) |-> arr_addr > $past(arr_addr));

  a_r5_busy_from_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

  a_r10_clr_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !busy && !wel_clr);

  a_r10_clr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> busy && !arr_valid);

  a_r9_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |-> busy);
endmodule

bind page_write_buffer pwb_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .OFF_W ($clog2(PAGE_BYTES))
) u_pwb_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_rise  (cs_rise),
  .busy     (busy),
  .arr_valid(arr_valid),
  .arr_ready(arr_ready),
  .arr_addr (arr_addr),
  .arr_data (arr_data),
  .wel_clr  (wel_clr)
);

// File: tb/page_write_buffer_test.sv
module page_write_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic [15:0] start_addr = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        byte_aligned = 1'b0;
  logic        cs_rise = 1'b0;
  logic        arr_valid;
  logic        arr_ready = 1'b1;
  logic [15:0] arr_addr;
  logic [7:0]  arr_data;
  logic        busy;
  logic        wel_clr;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  int bp_pct = 25;

  // monitor state
  int          nw;
  logic [15:0] w_addr [32];
  logic [7:0]  w_data [32];
  int          last_hs;
  int          nclr;
  int          clr_cyc;
  int          busy_seen;
  int          busy_after_clr;
  int          ready_errs;
  logic        prev_clr;

  // model state
  logic [15:0] m_mask;
  logic [7:0]  m_buf [16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  page_write_buffer #(.SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .byte_aligned(byte_aligned), .cs_rise(cs_rise), .arr_valid(arr_valid),
    .arr_ready(arr_ready), .arr_addr(arr_addr), .arr_data(arr_data),
    .busy(busy), .wel_clr(wel_clr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    nw = 0; nclr = 0; clr_cyc = -1; last_hs = -1; busy_seen = 0;
    busy_after_clr = -1; ready_errs = 0; prev_clr = 1'b0;
  endtask

  // Drive at the falling edge; outputs seen 1 time unit later are the ones
  // present at the next rising edge together with these inputs.
  task automatic step(input bit sv, input logic [15:0] sa, input bit iv,
                      input logic [7:0] id, input bit cr, input bit al);
    @(negedge clk);
    start_valid = sv; start_addr = sa; in_valid = iv; in_data = id;
    cs_rise = cr; byte_aligned = al;
    arr_ready = (($urandom % 100) >= bp_pct);
    #1;
    cyc++;
    if (prev_clr) busy_after_clr = busy;
    prev_clr = wel_clr;
    if (in_ready == busy) ready_errs++;
    if (busy) busy_seen++;
    if (arr_valid && arr_ready) begin
      if (nw < 32) begin
        w_addr[nw] = arr_addr;
        w_data[nw] = arr_data;
      end
      nw++;
      last_hs = cyc;
    end
    if (wel_clr) begin
      nclr++;
      clr_cyc = cyc;
    end
  endtask

  function automatic int popc(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += m[i];
    return c;
  endfunction

  // One session: start, bytes, chip-select rise, drain, and the checks.
  task automatic session(input logic [15:0] addr, input int nbytes, input bit al,
                         input bit same_cyc, input bit junk_before);
    logic [3:0] off;
    bit         commit;
    int         cs_cyc;
    int         k;
    int         busy_at_cs1;
    clear_mon();
    m_mask = '0;
    if (junk_before) begin
      // R11: bytes with no session open must be dropped
      step(0, '0, 1, 8'($urandom), 0, 0);
      step(0, '0, 1, 8'($urandom), 0, 0);
    end
    step(1, addr, 0, 0, 0, 0);
    off = addr[3:0];
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      m_buf[off] = d;
      m_mask[off] = 1'b1;
      if (i == nbytes - 1 && same_cyc) begin
        step(0, '0, 1, d, 1, al);
      end else begin
        step(0, '0, 1, d, 0, 0);
        if ($urandom % 4 == 0) step(0, '0, 0, 0, 0, 0);
      end
      off = off + 4'd1;
    end
    if (!(same_cyc && nbytes > 0)) step(0, '0, 0, 0, 1, al);
    cs_cyc = cyc;
    commit = al && (nbytes > 0);
    step(0, '0, 0, 0, 0, 0);
    busy_at_cs1 = busy;
    if (commit) check(busy_at_cs1 == 1, "R5", "busy after commit", busy_at_cs1, 1);
    else        check(busy_at_cs1 == 0, "R6", "busy after discard", busy_at_cs1, 0);
    k = 0;
    while (busy && k < 200) begin
      // R9: start, bytes and chip-select rise while busy must have no effect
      step($urandom % 2, 16'($urandom), $urandom % 2, 8'($urandom), $urandom % 2, 1);
      k++;
    end
    step(0, '0, 0, 0, 0, 0);
    step(0, '0, 0, 0, 0, 0);
    check(ready_errs == 0, "R9", "in_ready vs busy mismatches", ready_errs, 0);
    if (commit) begin
      int wi = 0;
      check(nw == popc(m_mask), "R7", "array write count", nw, popc(m_mask));
      for (int p = 0; p < 16; p++) begin
        if (m_mask[p] && wi < nw && wi < 32) begin
          check(w_addr[wi] == {addr[15:4], 4'(p)}, "R2", "array address",
                w_addr[wi], {addr[15:4], 4'(p)});
          check(w_data[wi] == m_buf[p], "R4", "array data", w_data[wi], m_buf[p]);
          wi++;
        end
      end
      check(nclr == 1, "R10", "wel_clr pulse count", nclr, 1);
      check(clr_cyc == last_hs + SETTLE, "R9", "settle after last write",
            clr_cyc - last_hs, SETTLE);
      check(busy_after_clr == 0, "R10", "busy after wel_clr", busy_after_clr, 0);
    end else begin
      check(nw == 0, "R6", "writes after discard", nw, 0);
      check(nclr == 0, "R6", "wel_clr after discard", nclr, 0);
      check(busy_seen == 0, "R6", "busy cycles after discard", busy_seen, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    check(busy == 0, "R1", "busy at reset", busy, 0);
    check(arr_valid == 0, "R1", "arr_valid at reset", arr_valid, 0);
    check(wel_clr == 0, "R1", "wel_clr at reset", wel_clr, 0);
    check(in_ready == 1, "R1", "in_ready at reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    session(16'h1234, 1, 1, 0, 0);   // single byte, R2
    session(16'h00EE, 5, 1, 0, 0);   // R3 wrap from offset 14
    session(16'hABC7, 20, 1, 0, 0);  // R4 overwrite after wrap
    session(16'h0400, 3, 0, 0, 0);   // R6 misaligned rise
    session(16'h0400, 0, 1, 0, 0);   // R6 no data bytes
    session(16'h7FF3, 1, 1, 1, 0);   // R12 lone byte with the rise
    session(16'h3339, 6, 1, 1, 1);   // R12 and R11
    bp_pct = 70;
    session(16'hFFFF, 16, 1, 0, 0);  // R8 heavy back-pressure, full page

    // random sessions
    for (int s = 0; s < 60; s++) begin
      bp_pct = $urandom % 60;
      session(16'($urandom), $urandom % 24, ($urandom % 5) != 0,
              $urandom % 2, ($urandom % 3) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule